// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of a 10-bit current-steering converter. It takes an input word (bit 9 is the most significant), an inversion control and a clock. An optional fold stage flips the lower nine bits when the control is high and the top bit is low. This lets a quarter-wave phase ramp drive the converter without extra external logic.

The folded word is captured on the rising clock edge. It is then split into segments. The top four bits become 15 thermometer lines, each worth 64 LSB units. The lower six bits pass straight through as binary weights, through a register that matches the decode stage. Both segment paths therefore change on the same edge.

Alongside the segments, the block reports two weight counts: the units steered to the true output and the units steered to the complementary output. These serve as a cross-check for the downstream switch array.

Top module: `segdac_frontend`

## Requirements
- R1: Every output reflects the word present at a rising edge exactly two rising edges later. Thermometer lines, binary bits and weights all move on the same edge.
- R2: With `inv_i` low, the captured word equals `data_i` unchanged.
- R3: With `inv_i` high and `data_i[9]` low, the captured word keeps bit 9 and has bits 8..0 inverted.
- R4: With `inv_i` high and `data_i[9]` high, the captured word equals `data_i` unchanged.
- R5: For a captured top field k = word[9:6], thermometer line i is set exactly when i < k. `therm_o` is therefore (1<<k)-1, with line 0 at bit 0.
- R6: `bin_o` equals bits 5..0 of the captured word.
- R7: `wt_true_o` equals 64 times the number of set thermometer lines plus `bin_o`. An all-ones word gives 1023 and an all-zeros word gives 0.
- R8: `wt_true_o + wt_comp_o` is always 1023.
- R9: A synchronous active-high `rst` clears the outputs at the next edge to the zero-code state: no thermometer lines, `bin_o` zero, `wt_true_o` 0 and `wt_comp_o` 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 10 | Input code, bit 9 most significant |
| inv_i | input | 1 | Fold control for the lower nine bits |
| therm_o | output | 15 | Thermometer lines for the top four bits |
| bin_o | output | 6 | Binary lines for the lower six bits |
| wt_true_o | output | 10 | LSB units steered to the true output |
| wt_comp_o | output | 10 | LSB units steered to the complementary output |

## Verification
The assertions assume that `data_i` and `inv_i` hold known values at every rising edge once reset has been released. The fold checks compare the captured word against the previous cycle's inputs, so they assume the inputs are stable across each edge. The stimulus changes inputs only on falling clock edges and never leaves them undriven. It sweeps every code with the fold control both low and high. It also asserts reset while a non-zero word is applied, so the zero-code state is seen under a live input.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int DATA_W = 10;
  localparam int SEG_W  = 4;
endpackage

// File: rtl/segdac_fold.sv
module segdac_fold #(
  parameter int DATA_W = segdac_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              inv_i,
  output logic [DATA_W-1:0] word_o,
  output logic              fold_hit_o
);
  // Fold: lower bits flip only when the control is set and the top bit is clear.
  function automatic logic [DATA_W-1:0] fold_word(input logic [DATA_W-1:0] w, input logic en);
    logic [DATA_W-1:0] r;
    r = w;
    if (en && !w[DATA_W-1]) r[DATA_W-2:0] = ~w[DATA_W-2:0];
    return r;
  endfunction

  assign word_o     = fold_word(word_i, inv_i);
  assign fold_hit_o = inv_i & ~word_i[DATA_W-1];
endmodule

// File: rtl/segdac_therm.sv
module segdac_therm #(
  parameter int SEG_W = segdac_pkg::SEG_W,
  localparam int LINES = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0] code_i,
  output logic [LINES-1:0] lines_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines_o[i] = (int'(code_i) > i);
  end
endmodule

// File: rtl/segdac_align.sv
module segdac_align #(
  parameter int W     = 6,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] taps [DEPTH+1];
  assign taps[0] = d_i;
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) taps[s+1] <= '0;
      else     taps[s+1] <= taps[s];
    end
  end
  assign q_o = taps[DEPTH];
endmodule

// File: rtl/segdac_frontend.sv
module segdac_frontend #(
  parameter int DATA_W = segdac_pkg::DATA_W,
  parameter int SEG_W  = segdac_pkg::SEG_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       inv_i,
  output logic [(1 << SEG_W)-2:0]    therm_o,
  output logic [DATA_W-SEG_W-1:0]    bin_o,
  output logic [DATA_W-1:0]          wt_true_o,
  output logic [DATA_W-1:0]          wt_comp_o
);
  localparam int BIN_W   = DATA_W - SEG_W;
  localparam int THERM_N = (1 << SEG_W) - 1;
  localparam int UNIT    = 1 << BIN_W;
  localparam int FULL    = (1 << DATA_W) - 1;

  // Units carried by a set of thermometer lines plus a binary field.
  function automatic logic [DATA_W-1:0] seg_weight(input logic [THERM_N-1:0] lines,
                                                   input logic [BIN_W-1:0]   low);
    int n;
    n = 0;
    for (int i = 0; i < THERM_N; i++) n += int'(lines[i]);
    return DATA_W'(n * UNIT) + DATA_W'(low);
  endfunction

  // Named internal events for the checker.
  logic [DATA_W-1:0]  fold_w;
  logic               fold_hit;
  logic [DATA_W-1:0]  stage_q;
  logic [SEG_W-1:0]   seg_code;
  logic [BIN_W-1:0]   seg_low;
  logic [THERM_N-1:0] therm_d;

  segdac_fold #(.DATA_W(DATA_W)) u_fold (
    .word_i(data_i), .inv_i(inv_i), .word_o(fold_w), .fold_hit_o(fold_hit)
  );

  // Capture register.
  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= fold_w;
  end

  assign seg_code = stage_q[DATA_W-1:BIN_W];
  assign seg_low  = stage_q[BIN_W-1:0];

  segdac_therm #(.SEG_W(SEG_W)) u_therm (.code_i(seg_code), .lines_o(therm_d));

  // Decode stage: thermometer lines and weight counts.
  always_ff @(posedge clk) begin
    if (rst) begin
      therm_o   <= '0;
      wt_true_o <= '0;
      wt_comp_o <= DATA_W'(FULL);
    end else begin
      therm_o   <= therm_d;
      wt_true_o <= seg_weight(therm_d, seg_low);
      wt_comp_o <= seg_weight(~therm_d, ~seg_low);
    end
  end

  // Binary path delayed to line up with the decode stage.
  segdac_align #(.W(BIN_W), .DEPTH(1)) u_align (
    .clk(clk), .rst(rst), .d_i(seg_low), .q_o(bin_o)
  );
endmodule

// File: rtl/segdac_chk.sv
module segdac_chk #(
  parameter int DATA_W = segdac_pkg::DATA_W,
  parameter int SEG_W  = segdac_pkg::SEG_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic [DATA_W-1:0]       data_i,
  input logic                    inv_i,
  input logic                    fold_hit,
  input logic [DATA_W-1:0]       stage_q,
  input logic [(1 << SEG_W)-2:0] therm_o,
  input logic [DATA_W-SEG_W-1:0] bin_o,
  input logic [DATA_W-1:0]       wt_true_o,
  input logic [DATA_W-1:0]       wt_comp_o
);
  localparam int BIN_W = DATA_W - SEG_W;
  localparam int UNIT  = 1 << BIN_W;
  localparam int FULL  = (1 << DATA_W) - 1;
  localparam int TW    = (1 << SEG_W) - 1;

  assert_pass_low_R2: assert property (@(posedge clk) disable iff (rst)
    !inv_i |=> stage_q == $past(data_i));

  assert_fold_R3: assert property (@(posedge clk) disable iff (rst)
    fold_hit |=> (stage_q[DATA_W-1] == $past(data_i[DATA_W-1])) &&
                 (stage_q[DATA_W-2:0] == ~$past(data_i[DATA_W-2:0])));

  assert_pass_msb_R4: assert property (@(posedge clk) disable iff (rst)
    (inv_i && data_i[DATA_W-1]) |=> stage_q == $past(data_i));

  assert_therm_shape_R5: assert property (@(posedge clk) disable iff (rst)
    ((therm_o + TW'(1)) & therm_o) == '0);

  assert_bin_align_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> bin_o == $past(stage_q[BIN_W-1:0]));

  assert_therm_align_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(therm_o) == int'($past(stage_q[DATA_W-1:BIN_W])));

  assert_weight_R7: assert property (@(posedge clk) disable iff (rst)
    int'(wt_true_o) == UNIT * $countones(therm_o) + int'(bin_o));

  assert_sum_R8: assert property (@(posedge clk) disable iff (rst)
    int'(wt_true_o) + int'(wt_comp_o) == FULL);

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (therm_o == '0) && (bin_o == '0) && (wt_true_o == '0) &&
            (int'(wt_comp_o) == FULL));
endmodule

bind segdac_frontend segdac_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst(rst), .data_i(data_i), .inv_i(inv_i), .fold_hit(fold_hit),
  .stage_q(stage_q), .therm_o(therm_o), .bin_o(bin_o),
  .wt_true_o(wt_true_o), .wt_comp_o(wt_comp_o)
);

// File: tb/sim_segdac_frontend.sv
module sim_segdac_frontend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  data_i = '0;
  logic        inv_i = 1'b0;
  logic [14:0] therm_o;
  logic [5:0]  bin_o;
  logic [9:0]  wt_true_o, wt_comp_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [14:0] th;
    logic [5:0]  bn;
    int          tw;
    int          cw;
  } exp_t;
  exp_t sb[$];

  segdac_frontend u0 (
    .clk(clk), .rst(rst), .data_i(data_i), .inv_i(inv_i),
    .therm_o(therm_o), .bin_o(bin_o), .wt_true_o(wt_true_o), .wt_comp_o(wt_comp_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: apply a word at the falling edge and queue its expected result.
  task automatic drive(input logic [9:0] d, input logic inv);
    exp_t e;
    logic [9:0] f;
    int k;
    @(negedge clk);
    data_i = d;
    inv_i  = inv;
    f = d;
    if (inv && (d[9] == 1'b0)) f = {1'b0, ~d[8:0]};   // R3 fold, R2/R4 pass
    k = int'(f) / 64;
    e.due = cyc + 2;                                   // R1 two-edge latency
    e.th  = 15'((1 << k) - 1);
    e.bn  = f[5:0];
    e.tw  = int'(f);
    e.cw  = 1023 - int'(f);
    sb.push_back(e);
  endtask

  // Monitor: compare queued results as they become due.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(therm_o == e.th, "R5/R1 therm", int'(therm_o), int'(e.th));
        check(bin_o == e.bn, "R6/R1 bin", int'(bin_o), int'(e.bn));
        check(int'(wt_true_o) == e.tw, "R7 true weight", int'(wt_true_o), e.tw);
        check(int'(wt_true_o) + int'(wt_comp_o) == 1023, "R8 sum",
              int'(wt_true_o) + int'(wt_comp_o), 1023);
      end
    end
  end

  task automatic check_zero_state(input string tag);
    check(therm_o == '0, {tag, " R9 therm"}, int'(therm_o), 0);
    check(bin_o == '0, {tag, " R9 bin"}, int'(bin_o), 0);
    check(wt_true_o == '0, {tag, " R9 true"}, int'(wt_true_o), 0);
    check(int'(wt_comp_o) == 1023, {tag, " R9 comp"}, int'(wt_comp_o), 1023);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check_zero_state("initial");
    @(negedge clk);
    rst = 1'b0;
    // Corners: all ones gives 1023, all zeros gives 0 (R7)
    drive(10'h3FF, 1'b0);
    drive(10'h000, 1'b0);
    drive(10'h3FF, 1'b1);      // R4: top bit set, no fold
    drive(10'h000, 1'b1);      // R3: folds to 0x1FF
    drive(10'h040, 1'b0);      // R5: one line
    drive(10'h3C0, 1'b0);      // R5: all fifteen lines
    // Full sweep, both fold settings
    for (int inv = 0; inv < 2; inv++) begin
      for (int c = 0; c < 1024; c++) drive(10'(c), inv[0]);
    end
    // Descending sweep with alternating fold control
    for (int c = 1023; c >= 0; c -= 7) drive(10'(c), c[0]);
    repeat (4) @(posedge clk);
    #2;
    check(sb.size() == 0, "R1 queue drained", sb.size(), 0);
    // Reset with a live non-zero word applied
    @(negedge clk);
    data_i = 10'h2AB;
    inv_i  = 1'b1;
    rst    = 1'b1;
    @(posedge clk);
    #2;
    check_zero_state("live");
    @(negedge clk);
    rst = 1'b0;
    drive(10'h155, 1'b1);      // R3 after reset
    repeat (4) @(posedge clk);
    #2;
    finish_run();
  end
endmodule